// File: doc/BRIEF.md
# Read-Only Host Port to 8-bit I/O Bus Bridge

This block lets a host whose expansion port can only issue read cycles drive a small I/O device on an 8-bit ISA bus. The host selects the direction of each transfer by the window it reads from. Host address bit 16 clear is the read window. Host address bit 16 set is the write window, 0x10000 above the read window base. A five-bit register index taken from the host address picks one of 32 I/O locations at fixed base 0x300. For a write, the byte to store travels on host address bits 8:1, because the port has no data path toward the device.

Each host cycle is turned into one sequenced bus transfer. The sequence places the address and data on the bus, waits one setup clock, raises a strobe for a fixed number of clocks, and then holds everything until the host drops its select. A read returns the device byte on the upper host data lane.

A wide mode serves devices that need 16-bit transfers. In this mode a read moves all sixteen data lines straight through. A 16-bit write takes two host cycles. First, a read-window access parks a low byte from the address bits in a holding latch. Then a write-window access supplies the high byte and issues the full-width write.

Top module: `romisa_bridge`

## Requirements
- R1: The bus address `isa_addr` of every transfer equals 0x300 plus host address bits 13:9. Bits 13:9 carry the register index, so index k gives address 0x300+k.
- R2: An access with host address bit 16 clear pulses only `isa_rd_stb`. An access with bit 16 set pulses only `isa_wr_stb` and raises `isa_dout_en`. The two strobes are never high together.
- R3: In byte mode (`mode_wide`=0), a read returns `isa_din[7:0]` on `host_rdata[15:8]` and returns zero on `host_rdata[7:0]`.
- R4: In byte mode, a write drives host address bits 8:1 onto `isa_dout[7:0]` and drives zero onto `isa_dout[15:8]`, with `isa_wide` low.
- R5: In wide mode (`mode_wide`=1), a read returns all of `isa_din[15:0]` unchanged on `host_rdata`, with `isa_wide` high during the transfer.
- R6: In wide mode, a read-window access also captures host address bits 8:1 as the pending low byte and marks it valid. A following write-window access drives `isa_dout` = {host address bits 8:1, pending low byte} and then clears the valid mark.
- R7: Reset clears the pending low byte and its valid mark. A wide write made while the mark is clear uses 0x00 as its low byte. Byte-mode reads leave the pending byte and its mark untouched.
- R8: The address and write data are stable for one clock before a strobe rises. While the select stays high, the strobe then stays high for exactly PULSE_CLKS clocks.
- R9: Read data is registered as the strobe ends and is held on `host_rdata` until the select drops. `host_rdata` then returns to zero one clock later.
- R10: `mode_wide` is sampled only when a host cycle begins. Changing it during a cycle has no effect on that cycle.
- R11: If the select drops while a strobe is high, the strobe is released on the next clock and the bus address is unchanged. No read data is captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wide | input | 1 | 1 = 16-bit mode, 0 = byte mode |
| host_sel | input | 1 | Host port select, high for a whole host cycle |
| host_addr | input | 17 | Host address: bit 16 window, 13:9 register index, 8:1 write byte |
| host_rdata | output | 16 | Data returned to the host |
| isa_addr | output | 10 | I/O bus address |
| isa_din | input | 16 | Data driven by the device during reads |
| isa_dout | output | 16 | Data driven toward the device during writes |
| isa_dout_en | output | 1 | Write data drive enable |
| isa_rd_stb | output | 1 | Read strobe, active high |
| isa_wr_stb | output | 1 | Write strobe, active high |
| isa_wide | output | 1 | High while a 16-bit transfer is in progress |

## Verification
The hardest state to reach from the ports is the pending low byte. It is set only by a wide read and consumed only by a wide write, and it must survive byte-mode reads in between. The bench therefore runs its vector table as ordered sequences: a wide read, byte-mode reads, then a wide write that must carry the parked byte. A second wide write with nothing parked must fall back to zero. An abort in the middle of a strobe and a mode flip during a cycle need exact timing, so the bench drives both at counted falling edges after the select rises.

// File: rtl/romisa_pkg.sv
package romisa_pkg;
  localparam int HOST_AW = 17;
  localparam int WIN_BIT = 16;
  localparam int REG_LSB = 9;
  localparam int REG_W   = 5;
  localparam int DAT_LSB = 1;
  localparam int BYTE_W  = 8;
  localparam int ISA_AW  = 10;
  localparam int HDW     = 2 * BYTE_W;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2,
    ST_HOLD   = 2'd3
  } seq_state_t;

  function automatic logic [ISA_AW-1:0] form_isa_addr(
      input logic [ISA_AW-1:0] base, input logic [REG_W-1:0] idx);
    return base | {{(ISA_AW-REG_W){1'b0}}, idx};
  endfunction

  function automatic logic [HDW-1:0] steer_read(
      input logic wide, input logic [HDW-1:0] din);
    return wide ? din : {din[BYTE_W-1:0], {BYTE_W{1'b0}}};
  endfunction

  function automatic logic [HDW-1:0] pack_write(
      input logic wide, input logic [BYTE_W-1:0] addr_byte,
      input logic [BYTE_W-1:0] low_byte, input logic low_ok);
    logic [BYTE_W-1:0] lo;
    lo = low_ok ? low_byte : {BYTE_W{1'b0}};
    return wide ? {addr_byte, lo} : {{BYTE_W{1'b0}}, addr_byte};
  endfunction
endpackage

// File: rtl/romisa_decode.sv
module romisa_decode
  import romisa_pkg::*;
(
  input  logic [HOST_AW-1:0] host_addr,
  output logic               win_wr,
  output logic [REG_W-1:0]   reg_idx,
  output logic [BYTE_W-1:0]  addr_byte
);
  logic unused_bits;

  assign win_wr    = host_addr[WIN_BIT];
  assign reg_idx   = host_addr[REG_LSB +: REG_W];
  assign addr_byte = host_addr[DAT_LSB +: BYTE_W];
  assign unused_bits = ^{host_addr[WIN_BIT-1:REG_LSB+REG_W]};
endmodule

// File: rtl/romisa_seq.sv
module romisa_seq
  import romisa_pkg::*;
#(
  parameter int PULSE_CLKS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_sel,
  output seq_state_t state,
  output logic       start_evt,
  output logic       pulse_end,
  output logic       done_evt,
  output logic       strobe_on,
  output logic       busy
);
  localparam int CW = (PULSE_CLKS > 1) ? $clog2(PULSE_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(PULSE_CLKS - 1);

  logic [CW-1:0] cnt;

  assign start_evt = (state == ST_IDLE) && host_sel;
  assign pulse_end = (state == ST_STROBE) && host_sel && (cnt == LAST);
  assign done_evt  = (state == ST_HOLD) && !host_sel;
  assign strobe_on = (state == ST_STROBE);
  assign busy      = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (host_sel) state <= ST_SETUP;
        end
        ST_SETUP: begin
          cnt <= '0;
          state <= host_sel ? ST_STROBE : ST_IDLE;
        end
        ST_STROBE: begin
          if (!host_sel || cnt == LAST) state <= ST_HOLD;
          else cnt <= cnt + 1'b1;
        end
        ST_HOLD: begin
          if (!host_sel) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_on |-> (cnt <= LAST));

  // R8
  setup_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_on) |-> ($past(state) == ST_SETUP));

  // R11
  abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_on && !host_sel) |=> !strobe_on);
endmodule

// File: rtl/romisa_lowlatch.sv
module romisa_lowlatch
  import romisa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [BYTE_W-1:0] cap_byte,
  input  logic              consume,
  output logic [BYTE_W-1:0] low_byte,
  output logic              low_valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_byte  <= '0;
      low_valid <= 1'b0;
    end else if (cap_en) begin
      low_byte  <= cap_byte;
      low_valid <= 1'b1;
    end else if (consume) begin
      low_valid <= 1'b0;
    end
  end

  // R6
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> (low_valid && low_byte == $past(cap_byte)));

  // R6
  consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !cap_en) |=> !low_valid);

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_en && !consume) |=> ($stable(low_byte) && $stable(low_valid)));
endmodule

// File: rtl/romisa_bridge.sv
module romisa_bridge
  import romisa_pkg::*;
#(
  parameter logic [ISA_AW-1:0] ISA_BASE   = 10'h300,
  parameter int                PULSE_CLKS = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_wide,
  input  logic               host_sel,
  input  logic [HOST_AW-1:0] host_addr,
  output logic [HDW-1:0]     host_rdata,
  output logic [ISA_AW-1:0]  isa_addr,
  input  logic [HDW-1:0]     isa_din,
  output logic [HDW-1:0]     isa_dout,
  output logic               isa_dout_en,
  output logic               isa_rd_stb,
  output logic               isa_wr_stb,
  output logic               isa_wide
);
  logic              win_wr;
  logic [REG_W-1:0]  reg_idx;
  logic [BYTE_W-1:0] addr_byte;
  seq_state_t        state;
  logic              start_evt, pulse_end, done_evt, strobe_on, busy;
  logic              cap_en, consume;
  logic [BYTE_W-1:0] low_byte;
  logic              low_valid;
  logic              cyc_wr, cyc_wide;
  logic [HDW-1:0]    rdata_q;
  logic [ISA_AW-1:0] addr_q;
  logic [HDW-1:0]    dout_q;

  romisa_decode u_dec (
    .host_addr (host_addr),
    .win_wr    (win_wr),
    .reg_idx   (reg_idx),
    .addr_byte (addr_byte)
  );

  romisa_seq #(.PULSE_CLKS(PULSE_CLKS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_sel  (host_sel),
    .state     (state),
    .start_evt (start_evt),
    .pulse_end (pulse_end),
    .done_evt  (done_evt),
    .strobe_on (strobe_on),
    .busy      (busy)
  );

  assign cap_en  = start_evt && mode_wide && !win_wr;
  assign consume = start_evt && mode_wide && win_wr;

  romisa_lowlatch u_lat (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_en    (cap_en),
    .cap_byte  (addr_byte),
    .consume   (consume),
    .low_byte  (low_byte),
    .low_valid (low_valid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_wr   <= 1'b0;
      cyc_wide <= 1'b0;
      addr_q   <= ISA_BASE;
      dout_q   <= '0;
    end else if (start_evt) begin
      cyc_wr   <= win_wr;
      cyc_wide <= mode_wide;
      addr_q   <= form_isa_addr(ISA_BASE, reg_idx);
      dout_q   <= win_wr ? pack_write(mode_wide, addr_byte, low_byte, low_valid) : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else if (done_evt) rdata_q <= '0;
    else if (pulse_end && !cyc_wr) rdata_q <= steer_read(cyc_wide, isa_din);
  end

  assign host_rdata  = rdata_q;
  assign isa_addr    = addr_q;
  assign isa_dout    = dout_q;
  assign isa_dout_en = busy && cyc_wr;
  assign isa_rd_stb  = strobe_on && !cyc_wr;
  assign isa_wr_stb  = strobe_on && cyc_wr;
  assign isa_wide    = busy && cyc_wide;

  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(isa_rd_stb && isa_wr_stb));

  // R2
  rd_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    isa_rd_stb |-> !isa_dout_en);

  // R8
  setup_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(isa_rd_stb || isa_wr_stb) |-> ($stable(isa_addr) && $stable(isa_dout)));

  // R11
  release_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(isa_rd_stb || isa_wr_stb) |-> ($stable(isa_addr) && $stable(isa_dout)));

  // R9
  rdata_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (host_rdata == '0));

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_HOLD && state == ST_HOLD) |-> $stable(host_rdata));

  // R10
  mode_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start_evt && $past(busy)) |-> $stable(isa_wide));
endmodule

// File: tb/tb_romisa_bridge.sv
module tb_romisa_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int PULSE = 3;
  localparam int WATCHDOG = 20000;
  localparam int NVEC = 10;
  // {mode, wr, reg[4:0], byte[7:0], din[15:0]}
  localparam logic [30:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 5'd0,  8'h00, 16'hBEEF},
    {1'b0, 1'b0, 5'd31, 8'h00, 16'h12A5},
    {1'b0, 1'b1, 5'd7,  8'h3C, 16'h0000},
    {1'b0, 1'b1, 5'd16, 8'hFF, 16'h0000},
    {1'b1, 1'b1, 5'd2,  8'h81, 16'h0000},
    {1'b1, 1'b0, 5'd4,  8'h5A, 16'hC3D2},
    {1'b0, 1'b0, 5'd9,  8'h77, 16'h0F96},
    {1'b1, 1'b1, 5'd4,  8'hE1, 16'h0000},
    {1'b1, 1'b1, 5'd4,  8'h42, 16'h0000},
    {1'b1, 1'b0, 5'd21, 8'h00, 16'h8001}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_wide = 1'b0;
  logic        host_sel = 1'b0;
  logic [16:0] host_addr = '0;
  logic [15:0] host_rdata;
  logic [9:0]  isa_addr;
  logic [15:0] isa_din = '0;
  logic [15:0] isa_dout;
  logic        isa_dout_en, isa_rd_stb, isa_wr_stb, isa_wide;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [7:0] m_low = 8'h00;
  bit m_valid = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  romisa_bridge #(.ISA_BASE(10'h300), .PULSE_CLKS(PULSE)) dut (
    .clk(clk), .rst_n(rst_n), .mode_wide(mode_wide), .host_sel(host_sel),
    .host_addr(host_addr), .host_rdata(host_rdata), .isa_addr(isa_addr),
    .isa_din(isa_din), .isa_dout(isa_dout), .isa_dout_en(isa_dout_en),
    .isa_rd_stb(isa_rd_stb), .isa_wr_stb(isa_wr_stb), .isa_wide(isa_wide)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input bit md, input bit wr, input logic [4:0] idx,
                        input logic [7:0] b, input logic [15:0] din, input bit flip);
    logic [9:0]  e_addr;
    logic [15:0] e_out;
    logic [15:0] e_rd;
    int width;
    bit wrong;
    e_addr = 10'd768 + 10'(idx);
    if (md) e_out = wr ? (16'(b) * 16'd256 + (m_valid ? 16'(m_low) : 16'd0)) : 16'd0;
    else    e_out = wr ? 16'(b) : 16'd0;
    e_rd = md ? din : 16'(din[7:0]) * 16'd256;
    @(negedge clk);
    mode_wide = md;
    isa_din = din;
    host_addr = {wr, 2'b00, idx, b, 1'b0};
    host_sel = 1'b1;
    @(negedge clk);
    if (flip) mode_wide = ~md;
    check(!isa_rd_stb && !isa_wr_stb, "R8 setup clock without strobe",
          {30'd0, isa_rd_stb, isa_wr_stb}, 32'd0);
    check(isa_addr == e_addr, "R1 bus address", 32'(isa_addr), 32'(e_addr));
    if (wr) check(isa_dout == e_out, md ? "R6/R7 wide write data" : "R4 byte write data",
                  32'(isa_dout), 32'(e_out));
    check(isa_dout_en == wr, "R2 drive enable", 32'(isa_dout_en), 32'(wr));
    check(isa_wide == md, "R5/R4/R10 width flag", 32'(isa_wide), 32'(md));
    @(negedge clk);
    width = 0;
    wrong = 0;
    while ((isa_rd_stb || isa_wr_stb) && width < 50) begin
      if (wr ? isa_rd_stb : isa_wr_stb) wrong = 1;
      width++;
      @(negedge clk);
    end
    check(!wrong, "R2 strobe matches window", 32'(wrong), 32'd0);
    check(width == PULSE, "R8 strobe width", 32'(width), 32'(PULSE));
    if (!wr) check(host_rdata == e_rd, md ? "R5 wide read data" : "R3 byte read data",
                   32'(host_rdata), 32'(e_rd));
    @(negedge clk);
    if (!wr) check(host_rdata == e_rd, "R9 read data held", 32'(host_rdata), 32'(e_rd));
    host_sel = 1'b0;
    @(negedge clk);
    check(host_rdata == 16'd0, "R9 read data cleared", 32'(host_rdata), 32'd0);
    if (md && !wr) begin m_low = b; m_valid = 1; end
    if (md && wr) m_valid = 0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    check(!isa_rd_stb && !isa_wr_stb, "R8 no strobe in reset", 32'(isa_rd_stb), 32'd0);
    check(host_rdata == 16'd0, "R9 reset read data", 32'(host_rdata), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(isa_dout_en == 1'b0 && isa_wide == 1'b0, "R2 idle after reset",
          {31'd0, isa_dout_en}, 32'd0);
    // R7: wide write straight after reset uses zero low byte
    access(1'b1, 1'b1, 5'd3, 8'hA0, 16'h0, 1'b0);
    // table walk
    for (int i = 0; i < NVEC; i++)
      access(VEC[i][30], VEC[i][29], VEC[i][28:24], VEC[i][23:16], VEC[i][15:0], 1'b0);
    // R7: byte-mode reads between capture and write leave the latch intact
    access(1'b1, 1'b0, 5'd1, 8'h6E, 16'h1111, 1'b0);
    access(1'b0, 1'b0, 5'd2, 8'h99, 16'h2233, 1'b0);
    access(1'b0, 1'b1, 5'd5, 8'h13, 16'h0, 1'b0);
    access(1'b1, 1'b1, 5'd1, 8'hD4, 16'h0, 1'b0);
    // R10: mode flips during a wide read and a byte read
    access(1'b1, 1'b0, 5'd8, 8'h00, 16'hFACE, 1'b1);
    access(1'b0, 1'b0, 5'd8, 8'h00, 16'hFACE, 1'b1);
    m_valid = 0;
    // R11: select dropped mid-strobe
    @(negedge clk);
    mode_wide = 1'b0;
    isa_din = 16'h00AB;
    host_addr = {1'b0, 2'b00, 5'd11, 8'h00, 1'b0};
    host_sel = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(isa_rd_stb == 1'b1, "R11 strobe active before abort", 32'(isa_rd_stb), 32'd1);
    host_sel = 1'b0;
    @(negedge clk);
    check(isa_rd_stb == 1'b0, "R11 strobe released", 32'(isa_rd_stb), 32'd0);
    check(isa_addr == 10'd779, "R11 address unchanged", 32'(isa_addr), 32'd779);
    check(host_rdata == 16'd0, "R11 no data captured", 32'(host_rdata), 32'd0);
    @(negedge clk);
    // R7: reset clears latch
    access(1'b1, 1'b0, 5'd0, 8'hC7, 16'h0, 1'b0);
    rst_n = 1'b0;
    m_valid = 0;
    @(negedge clk);
    rst_n = 1'b1;
    access(1'b1, 1'b1, 5'd0, 8'h01, 16'h0, 1'b0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule